// File: doc/BRIEF.md
# Fast Interrupt Vector Override Unit

This unit sits beside a priority interrupt controller and lets software name up to two interrupt vector numbers as fast interrupts. For each fast channel, software programs a 7-bit vector number to watch for and a 21-bit handler address. The handler address is held in two registers: a 16-bit low half and a 5-bit high half. When a fast request is chosen, the CPU can branch straight to that handler address instead of going through the jump table.

Each cycle the unit sees every pending request slot, with its valid bit, its 2-bit priority level and its vector number. Only requests at level 2 take part. Normally the winner is the level-2 request with the lowest slot index, and the target address is the jump-table address that the controller supplies. A level-2 request whose vector number equals a fast channel's programmed value is lifted above all other level-2 requests. In that case the unit raises the fast flag and outputs that channel's handler address. Fast channel 0 beats fast channel 1.

The results are registered. Software reaches the registers over a small synchronous 16-bit bus.

Top module: `fast_irq_vec_unit`

## Requirements
- R1: Register offsets on the bus: channel 0 has its match register at 0xB, its address-low register at 0xC and its address-high register at 0xD. Channel 1 uses 0xE, 0xF and 0x10 for the same three registers. Read data appears on `bus_rdata_o` one cycle after `bus_rd_en_i` and is 0 in cycles with no read.
- R2: The match register keeps only bits 6..0 and the address-high register keeps only bits 4..0. The other bits read 0, and writing to them has no effect.
- R3: While reset is asserted, every register and every output is zero.
- R4: A valid request at level 2 (level code 2'd2) whose vector equals a channel's match value outranks every other level-2 request. The winner is reported with `fast_o`=1. If several requests match the same channel, the lowest slot index wins.
- R5: When requests matching both channels are pending, channel 0 wins. This also holds when both channels hold the same match value.
- R6: A request at any level other than 2 that matches a fast channel is not promoted and cannot win.
- R7: With no fast match pending, the winner is the lowest-index valid level-2 request, `fast_o` is 0 and `tgt_addr_o` equals `jt_addr_i`. With no level-2 request pending, `win_valid_o`, `win_idx_o` and `win_vec_o` are 0.
- R8: For a fast winner, `tgt_addr_o` is the winning channel's address-high bits 4..0 placed above its 16 address-low bits.
- R9: The outputs reflect the inputs sampled at the previous clock edge. A register write is first used in arbitration on the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_en_i | input | 1 | Register write strobe |
| bus_rd_en_i | input | 1 | Register read strobe |
| bus_addr_i | input | BUS_AW | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, one cycle after the read strobe |
| req_valid_i | input | NUM_REQ | Pending bit for each request slot |
| req_lvl_i | input | 2*NUM_REQ | Priority level of each slot |
| req_vec_i | input | 7*NUM_REQ | Vector number of each slot |
| jt_addr_i | input | 21 | Jump-table address of the normal winner |
| win_valid_o | output | 1 | A level-2 winner exists |
| win_idx_o | output | log2(NUM_REQ) | Slot index of the winner |
| win_vec_o | output | 7 | Vector number of the winner |
| fast_o | output | 1 | The winner is a fast interrupt |
| tgt_addr_o | output | 21 | Handler address or jump-table address |

## Verification
A bus write that retargets a fast channel can land in the same cycle as a pending request that matches the new value. The bench holds such a request steady across the write. It checks that the edge of the write still arbitrates with the old match value and that the next edge promotes the request. Fast-channel arbitration and the channel 0/1 collision also coincide: the sweeps use a vector space of only eight values, so both channels often match in the same cycle, including a setup where both channels hold the same value. Every output is compared with an arithmetic model of the rules.

// File: rtl/fivr_pkg.sv
package fivr_pkg;
  localparam int unsigned VEC_W    = 7;
  localparam int unsigned LVL_W    = 2;
  localparam int unsigned LO_W     = 16;
  localparam int unsigned HI_W     = 5;
  localparam int unsigned TGT_W    = LO_W + HI_W;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned BASE_OFF = 11;
  localparam int unsigned REGS_PER_CH = 3;
  localparam logic [LVL_W-1:0] LVL_FAST = 2'd2;

  function automatic int unsigned match_off(int unsigned ch);
    return BASE_OFF + REGS_PER_CH * ch;
  endfunction
endpackage

// File: rtl/fivr_pick.sv
module fivr_pick #(
  parameter int unsigned N    = 8,
  localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    hit_o = |mask_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/fivr_match.sv
module fivr_match
  import fivr_pkg::*;
#(
  parameter int unsigned N    = 8,
  localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       cand_i,
  input  logic [N*VEC_W-1:0] vec_i,
  input  logic [VEC_W-1:0]   match_i,
  output logic               hit_o,
  output logic [IW-1:0]      idx_o
);
  logic [N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_eq
    assign eq[i] = cand_i[i] && (vec_i[i*VEC_W +: VEC_W] == match_i);
  end

  fivr_pick #(.N(N)) u_pick (
    .mask_i(eq),
    .hit_o (hit_o),
    .idx_o (idx_o)
  );
endmodule

// File: rtl/fivr_regs.sv
module fivr_regs
  import fivr_pkg::*;
#(
  parameter int unsigned BUS_AW = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [BUS_AW-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [NUM_CH*VEC_W-1:0] match_o,
  output logic [NUM_CH*LO_W-1:0]  lo_o,
  output logic [NUM_CH*HI_W-1:0]  hi_o
);
  logic [DATA_W-1:0] rd_part [NUM_CH];
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rdata_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [BUS_AW-1:0] A_M  = BUS_AW'(match_off(c));
    localparam logic [BUS_AW-1:0] A_LO = BUS_AW'(match_off(c) + 1);
    localparam logic [BUS_AW-1:0] A_HI = BUS_AW'(match_off(c) + 2);

    logic [VEC_W-1:0] m_q;
    logic [LO_W-1:0]  lo_q;
    logic [HI_W-1:0]  hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        m_q  <= '0;
        lo_q <= '0;
        hi_q <= '0;
      end else if (wr_en_i) begin
        if (addr_i == A_M)  m_q  <= wdata_i[VEC_W-1:0];
        if (addr_i == A_LO) lo_q <= wdata_i[LO_W-1:0];
        if (addr_i == A_HI) hi_q <= wdata_i[HI_W-1:0];
      end
    end

    always_comb begin
      rd_part[c] = '0;
      if (addr_i == A_M)  rd_part[c] = DATA_W'(m_q);
      if (addr_i == A_LO) rd_part[c] = DATA_W'(lo_q);
      if (addr_i == A_HI) rd_part[c] = DATA_W'(hi_q);
    end

    assign match_o[c*VEC_W +: VEC_W] = m_q;
    assign lo_o[c*LO_W +: LO_W]      = lo_q;
    assign hi_o[c*HI_W +: HI_W]      = hi_q;
  end

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NUM_CH; c++) rd_next = rd_next | rd_part[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_next;
    else              rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/fast_irq_vec_unit.sv
module fast_irq_vec_unit
  import fivr_pkg::*;
#(
  parameter int unsigned NUM_REQ = 8,
  parameter int unsigned BUS_AW  = 6,
  localparam int unsigned IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_wr_en_i,
  input  logic                     bus_rd_en_i,
  input  logic [BUS_AW-1:0]        bus_addr_i,
  input  logic [DATA_W-1:0]        bus_wdata_i,
  output logic [DATA_W-1:0]        bus_rdata_o,
  input  logic [NUM_REQ-1:0]       req_valid_i,
  input  logic [NUM_REQ*LVL_W-1:0] req_lvl_i,
  input  logic [NUM_REQ*VEC_W-1:0] req_vec_i,
  input  logic [TGT_W-1:0]         jt_addr_i,
  output logic                     win_valid_o,
  output logic [IDX_W-1:0]         win_idx_o,
  output logic [VEC_W-1:0]         win_vec_o,
  output logic                     fast_o,
  output logic [TGT_W-1:0]         tgt_addr_o
);
  logic [NUM_CH*VEC_W-1:0] reg_match;
  logic [NUM_CH*LO_W-1:0]  reg_lo;
  logic [NUM_CH*HI_W-1:0]  reg_hi;

  fivr_regs #(.BUS_AW(BUS_AW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(bus_wr_en_i),
    .rd_en_i(bus_rd_en_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .match_o(reg_match),
    .lo_o   (reg_lo),
    .hi_o   (reg_hi)
  );

  logic [NUM_REQ-1:0] cand;
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_cand
    assign cand[i] = req_valid_i[i] && (req_lvl_i[i*LVL_W +: LVL_W] == LVL_FAST);
  end

  logic             ch_hit [NUM_CH];
  logic [IDX_W-1:0] ch_idx [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fast
    fivr_match #(.N(NUM_REQ)) u_match (
      .cand_i (cand),
      .vec_i  (req_vec_i),
      .match_i(reg_match[c*VEC_W +: VEC_W]),
      .hit_o  (ch_hit[c]),
      .idx_o  (ch_idx[c])
    );
  end

  logic             norm_hit;
  logic [IDX_W-1:0] norm_idx;

  fivr_pick #(.N(NUM_REQ)) u_norm (
    .mask_i(cand),
    .hit_o (norm_hit),
    .idx_o (norm_idx)
  );

  logic             sel_valid, sel_fast;
  logic [IDX_W-1:0] sel_idx;
  logic [VEC_W-1:0] sel_vec;
  logic [TGT_W-1:0] sel_addr;

  // lower channel number evaluated last so it wins
  always_comb begin
    sel_valid = norm_hit;
    sel_idx   = norm_idx;
    sel_fast  = 1'b0;
    sel_addr  = jt_addr_i;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (ch_hit[c]) begin
        sel_valid = 1'b1;
        sel_idx   = ch_idx[c];
        sel_fast  = 1'b1;
        sel_addr  = {reg_hi[c*HI_W +: HI_W], reg_lo[c*LO_W +: LO_W]};
      end
    end
    sel_vec = sel_valid ? req_vec_i[int'(sel_idx)*VEC_W +: VEC_W] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_valid_o <= 1'b0;
      win_idx_o   <= '0;
      win_vec_o   <= '0;
      fast_o      <= 1'b0;
      tgt_addr_o  <= '0;
    end else begin
      win_valid_o <= sel_valid;
      win_idx_o   <= sel_idx;
      win_vec_o   <= sel_vec;
      fast_o      <= sel_fast;
      tgt_addr_o  <= sel_addr;
    end
  end
endmodule

// File: rtl/fivr_chk.sv
module fivr_chk
  import fivr_pkg::*;
#(
  parameter int unsigned NUM_REQ = 8,
  parameter int unsigned BUS_AW  = 6,
  localparam int unsigned IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     bus_rd_en_i,
  input logic [BUS_AW-1:0]        bus_addr_i,
  input logic [DATA_W-1:0]        bus_rdata_o,
  input logic [NUM_REQ-1:0]       req_valid_i,
  input logic [NUM_REQ*LVL_W-1:0] req_lvl_i,
  input logic [NUM_REQ*VEC_W-1:0] req_vec_i,
  input logic [TGT_W-1:0]         jt_addr_i,
  input logic                     win_valid_o,
  input logic [IDX_W-1:0]         win_idx_o,
  input logic [VEC_W-1:0]         win_vec_o,
  input logic                     fast_o,
  input logic [TGT_W-1:0]         tgt_addr_o,
  input logic [NUM_CH*VEC_W-1:0]  reg_match,
  input logic [NUM_CH*LO_W-1:0]   reg_lo,
  input logic [NUM_CH*HI_W-1:0]   reg_hi
);
  logic [NUM_REQ-1:0]       vld_q;
  logic [NUM_REQ*LVL_W-1:0] lvl_q;
  logic [TGT_W-1:0]         jt_q;
  logic [VEC_W-1:0]         m0_q;
  logic [TGT_W-1:0]         a0_q;
  logic                     m0_pend_q;
  logic                     rd_narrow_q;
  logic                     m0_pend;

  always_comb begin
    m0_pend = 1'b0;
    for (int i = 0; i < NUM_REQ; i++)
      if (req_valid_i[i] && req_lvl_i[i*LVL_W +: LVL_W] == LVL_FAST &&
          req_vec_i[i*VEC_W +: VEC_W] == reg_match[VEC_W-1:0])
        m0_pend = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0; lvl_q <= '0; jt_q <= '0; m0_q <= '0; a0_q <= '0;
      m0_pend_q <= 1'b0; rd_narrow_q <= 1'b0;
    end else begin
      vld_q       <= req_valid_i;
      lvl_q       <= req_lvl_i;
      jt_q        <= jt_addr_i;
      m0_q        <= reg_match[VEC_W-1:0];
      a0_q        <= {reg_hi[HI_W-1:0], reg_lo[LO_W-1:0]};
      m0_pend_q   <= m0_pend;
      rd_narrow_q <= bus_rd_en_i && (bus_addr_i == BUS_AW'(match_off(0)) ||
                                     bus_addr_i == BUS_AW'(match_off(1)));
    end
  end

  // R4
  fast_has_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_o |-> win_valid_o);

  // R6
  win_is_lvl2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (vld_q[win_idx_o] && lvl_q[int'(win_idx_o)*LVL_W +: LVL_W] == LVL_FAST));

  // R5
  ch0_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m0_pend_q |-> (fast_o && win_vec_o == m0_q));

  // R8
  ch0_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m0_pend_q |-> (tgt_addr_o == a0_q));

  // R7
  slow_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fast_o |-> (tgt_addr_o == jt_q));

  // R2
  match_rd_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_narrow_q |-> (bus_rdata_o[DATA_W-1:VEC_W] == '0));

  // R1
  rd_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_rd_en_i) |=> (bus_rdata_o == '0));
endmodule

bind fast_irq_vec_unit fivr_chk #(.NUM_REQ(NUM_REQ), .BUS_AW(BUS_AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_rd_en_i(bus_rd_en_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .req_valid_i(req_valid_i),
  .req_lvl_i  (req_lvl_i),
  .req_vec_i  (req_vec_i),
  .jt_addr_i  (jt_addr_i),
  .win_valid_o(win_valid_o),
  .win_idx_o  (win_idx_o),
  .win_vec_o  (win_vec_o),
  .fast_o     (fast_o),
  .tgt_addr_o (tgt_addr_o),
  .reg_match  (reg_match),
  .reg_lo     (reg_lo),
  .reg_hi     (reg_hi)
);

// File: tb/fast_irq_vec_unit_test.sv
module fast_irq_vec_unit_test;
  localparam int N  = 8;
  localparam int AW = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_wr_en_i = 1'b0, bus_rd_en_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0, bus_rdata_o;
  logic [N-1:0]   req_valid_i = '0;
  logic [N*2-1:0] req_lvl_i = '0;
  logic [N*7-1:0] req_vec_i = '0;
  logic [20:0] jt_addr_i = '0;
  logic        win_valid_o, fast_o;
  logic [2:0]  win_idx_o;
  logic [6:0]  win_vec_o;
  logic [20:0] tgt_addr_o;

  fast_irq_vec_unit #(.NUM_REQ(N), .BUS_AW(AW)) uut (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int unsigned seed = 32'h1234_5678;

  // bench copy of programmed registers
  logic [6:0]  m_s [2];
  logic [15:0] lo_s [2];
  logic [4:0]  hi_s [2];

  // expected outputs
  logic        e_valid, e_fast;
  logic [2:0]  e_idx;
  logic [6:0]  e_vec;
  logic [20:0] e_addr;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [15:0] d);
    @(negedge clk_i);
    bus_wr_en_i = 1'b1; bus_addr_i = AW'(a); bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_en_i = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [15:0] d);
    @(negedge clk_i);
    bus_rd_en_i = 1'b1; bus_addr_i = AW'(a);
    @(posedge clk_i); #1;
    d = bus_rdata_o;
    @(negedge clk_i);
    bus_rd_en_i = 1'b0;
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic void model();
    int hit_ch = -1, hit_i = -1, norm_i = -1;
    for (int c = 1; c >= 0; c--) begin
      int first = -1;
      for (int i = 0; i < N; i++)
        if (first < 0 && req_valid_i[i] && req_lvl_i[i*2 +: 2] == 2'd2 &&
            req_vec_i[i*7 +: 7] == m_s[c]) first = i;
      if (first >= 0) begin hit_ch = c; hit_i = first; end
    end
    for (int i = N - 1; i >= 0; i--)
      if (req_valid_i[i] && req_lvl_i[i*2 +: 2] == 2'd2) norm_i = i;
    e_fast = (hit_ch >= 0);
    if (e_fast) begin
      e_valid = 1'b1; e_idx = 3'(hit_i);
      e_addr = {hi_s[hit_ch], lo_s[hit_ch]};
    end else begin
      e_valid = (norm_i >= 0); e_idx = (norm_i >= 0) ? 3'(norm_i) : 3'd0;
      e_addr = jt_addr_i;
    end
    e_vec = e_valid ? req_vec_i[int'(e_idx)*7 +: 7] : 7'd0;
  endfunction

  task automatic cmp_out(input string req);
    check(win_valid_o == e_valid, req, 64'(win_valid_o), 64'(e_valid));
    check(fast_o == e_fast,       req, 64'(fast_o), 64'(e_fast));
    check(win_idx_o == e_idx,     req, 64'(win_idx_o), 64'(e_idx));
    check(win_vec_o == e_vec,     req, 64'(win_vec_o), 64'(e_vec));
    check(tgt_addr_o == e_addr,   req, 64'(tgt_addr_o), 64'(e_addr));
  endtask

  task automatic prog(input int c, input logic [6:0] m, input logic [15:0] lo, input logic [4:0] hi);
    bus_write(11 + 3*c, 16'(m));  m_s[c] = m;
    bus_write(12 + 3*c, lo);      lo_s[c] = lo;
    bus_write(13 + 3*c, 16'(hi)); hi_s[c] = hi;
  endtask

  task automatic rand_inputs();
    for (int i = 0; i < N; i++) begin
      req_valid_i[i]     = (rnd() % 4) != 0;
      req_lvl_i[i*2 +: 2] = 2'(rnd());
      req_vec_i[i*7 +: 7] = 7'(rnd() % 8);
    end
    jt_addr_i = 21'(rnd());
  endtask

  task automatic sweep(input int cnt, input string req);
    logic        p_valid, p_fast;
    logic [2:0]  p_idx;
    logic [6:0]  p_vec;
    logic [20:0] p_addr;
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk_i);
      rand_inputs();
      if (k > 0) begin
        // R9: inputs changed, outputs must still hold previous result
        #1;
        check(win_vec_o == p_vec && win_idx_o == p_idx && fast_o == p_fast &&
              win_valid_o == p_valid && tgt_addr_o == p_addr,
              "R9 hold", 64'(tgt_addr_o), 64'(p_addr));
      end
      model();
      @(posedge clk_i); #1;
      cmp_out(req);
      p_valid = e_valid; p_fast = e_fast; p_idx = e_idx; p_vec = e_vec; p_addr = e_addr;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    for (int c = 0; c < 2; c++) begin m_s[c] = '0; lo_s[c] = '0; hi_s[c] = '0; end

    // R3: reset state
    #23;
    check(win_valid_o == 0 && fast_o == 0 && win_idx_o == 0 && win_vec_o == 0 &&
          tgt_addr_o == 0 && bus_rdata_o == 0, "R3 outputs", 64'(tgt_addr_o), 64'd0);
    rst_ni = 1'b1;
    for (int a = 11; a <= 16; a++) begin
      bus_read(a, rd);
      check(rd == 16'h0, "R3 reg reset", 64'(rd), 64'd0);
    end

    // zero match values after reset: vector 0 at level 2 is fast with address 0
    @(negedge clk_i);
    req_valid_i = 8'b0000_0110;
    req_lvl_i = '0; req_lvl_i[2 +: 2] = 2'd2; req_lvl_i[4 +: 2] = 2'd2;
    req_vec_i = '0; req_vec_i[7 +: 7] = 7'd9; req_vec_i[14 +: 7] = 7'd0;
    jt_addr_i = 21'h1ABCD;
    model();
    @(posedge clk_i); #1;
    cmp_out("R4 reset match");
    check(fast_o == 1 && win_idx_o == 2, "R4 reset match idx", 64'(win_idx_o), 64'd2);

    // R1/R2: register width masking and readback
    for (int c = 0; c < 2; c++) begin
      bus_write(11 + 3*c, 16'hFFFF);
      bus_write(12 + 3*c, 16'hFFFF);
      bus_write(13 + 3*c, 16'hFFFF);
      bus_read(11 + 3*c, rd); check(rd == 16'h007F, "R2 match mask", 64'(rd), 64'h7F);
      bus_read(12 + 3*c, rd); check(rd == 16'hFFFF, "R1 addr low",  64'(rd), 64'hFFFF);
      bus_read(13 + 3*c, rd); check(rd == 16'h001F, "R2 addr high", 64'(rd), 64'h1F);
    end
    @(posedge clk_i); #1;
    check(bus_rdata_o == 16'h0, "R1 idle rdata", 64'(bus_rdata_o), 64'd0);

    // R1: distinct values land at distinct offsets
    prog(0, 7'd3, 16'hA5A1, 5'h11);
    prog(1, 7'd5, 16'h5A52, 5'h0E);
    bus_read(11, rd); check(rd == 16'd3,    "R1 m0",  64'(rd), 64'd3);
    bus_read(12, rd); check(rd == 16'hA5A1, "R1 lo0", 64'(rd), 64'hA5A1);
    bus_read(13, rd); check(rd == 16'h11,   "R1 hi0", 64'(rd), 64'h11);
    bus_read(14, rd); check(rd == 16'd5,    "R1 m1",  64'(rd), 64'd5);
    bus_read(15, rd); check(rd == 16'h5A52, "R1 lo1", 64'(rd), 64'h5A52);
    bus_read(16, rd); check(rd == 16'h0E,   "R1 hi1", 64'(rd), 64'h0E);

    // R6: match at level 1 is ignored; level-2 non-match wins
    @(negedge clk_i);
    req_valid_i = 8'b0000_1001;
    req_lvl_i = '0; req_lvl_i[0 +: 2] = 2'd1; req_lvl_i[6 +: 2] = 2'd2;
    req_vec_i = '0; req_vec_i[0 +: 7] = 7'd3; req_vec_i[21 +: 7] = 7'd6;
    jt_addr_i = 21'h0F00F;
    model();
    @(posedge clk_i); #1;
    check(win_idx_o == 3 && fast_o == 0 && tgt_addr_o == 21'h0F00F,
          "R6 non-level2", 64'(win_idx_o), 64'd3);
    cmp_out("R7 normal winner");

    // R5: both channels match, channel 0 wins despite higher index
    @(negedge clk_i);
    req_valid_i = 8'b1000_0010;
    req_lvl_i = '0; req_lvl_i[2 +: 2] = 2'd2; req_lvl_i[14 +: 2] = 2'd2;
    req_vec_i = '0; req_vec_i[7 +: 7] = 7'd5; req_vec_i[49 +: 7] = 7'd3;
    model();
    @(posedge clk_i); #1;
    check(win_idx_o == 7 && fast_o && tgt_addr_o == {5'h11, 16'hA5A1},
          "R5 ch0 over ch1", 64'(tgt_addr_o), 64'({5'h11, 16'hA5A1}));

    // R7: nothing pending at level 2
    @(negedge clk_i);
    req_valid_i = 8'hFF; req_lvl_i = {N{2'd3}};
    model();
    @(posedge clk_i); #1;
    check(!win_valid_o && win_idx_o == 0 && win_vec_o == 0 && !fast_o,
          "R7 none pending", 64'(win_valid_o), 64'd0);

    // R9: write retargeting m1 coincident with a pending match on new value
    @(negedge clk_i);
    req_valid_i = 8'b0010_0001;
    req_lvl_i = '0; req_lvl_i[0 +: 2] = 2'd2; req_lvl_i[10 +: 2] = 2'd2;
    req_vec_i = '0; req_vec_i[0 +: 7] = 7'd1; req_vec_i[35 +: 7] = 7'd6;
    jt_addr_i = 21'h00777;
    bus_wr_en_i = 1'b1; bus_addr_i = AW'(14); bus_wdata_i = 16'd6;
    @(posedge clk_i); #1;
    check(!fast_o && win_idx_o == 0, "R9 write not yet used", 64'(fast_o), 64'd0);
    @(negedge clk_i);
    bus_wr_en_i = 1'b0; m_s[1] = 7'd6;
    @(posedge clk_i); #1;
    check(fast_o && win_idx_o == 5 && tgt_addr_o == {5'h0E, 16'h5A52},
          "R9 write used next cycle", 64'(win_idx_o), 64'd5);

    // sweeps over small vector space
    prog(0, 7'd3, 16'h1234, 5'h15);
    prog(1, 7'd5, 16'h9876, 5'h0A);
    sweep(400, "R4 sweep distinct");
    prog(1, 7'd3, 16'h4444, 5'h02);
    sweep(300, "R5 sweep shared");
    prog(0, 7'd7, 16'hFFFF, 5'h1F);
    prog(1, 7'd0, 16'h0001, 5'h00);
    sweep(300, "R8 sweep extremes");
    prog(0, 7'd100, 16'h2222, 5'h03);
    prog(1, 7'd101, 16'h3333, 5'h04);
    sweep(200, "R7 sweep no match");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule